// File: doc/BRIEF.md
# Entropy Accumulator with SHA-1 Conditioning

This block is the digital core of a hardware random number generator. A bank of 128 entropy source bits arrives as plain inputs; the analog sources themselves live outside. Each clock, 125 of those bits are XOR-folded into a 128-bit maximal-length LFSR. Every 81 cycles the accumulated LFSR state is captured and handed to an iterative SHA-1 engine. The engine runs one round per cycle, then spends one cycle on finalisation. The top 64 bits of each digest become one random word.

Words go into a 64-entry FIFO, which is read through a valid/ready port. Clearing the entropy enable ties the LFSR to its reset seed, so the hash sees a known message and the output becomes a fixed self-test value. A raw mode bypasses the hash and delivers folded source samples, one 64-bit word every 8 cycles.

Top module: `ent_cond_rng`

## Requirements
- R1: After reset is released, `rd_valid_o` stays low for the first 161 clock edges. The first conditioned word becomes visible right after edge 162, which is one 81-cycle accumulation window plus one 81-cycle hash pass.
- R2: A conditioned word is the upper 64 bits of the digest {H0,H1}. The digest is the standard SHA-1 of a 16-byte message whose bytes are the 128-bit LFSR snapshot, most significant byte first. The snapshot is the LFSR value produced by edges 81k, for k = 1, 2, 3, and so on.
- R3: In steady state, one conditioned word is produced every 81 cycles. With `rd_ready_i` held high, consecutive words are accepted exactly 81 cycles apart.
- R4: On each edge where `ent_en_i` is 1, the LFSR becomes {q[126:0], q[127]^q[125]^q[100]^q[98]} XOR {3'b0, src_i[124:0]}. Bits `src_i[127:125]` have no effect on any output.
- R5: While `ent_en_i` is 0, the LFSR is held at the seed 128'h5A3C96E10F87D2B41E2D3C4B5A697887. Every conditioned word then equals the R2 hash of that seed.
- R6: While `raw_mode_i` is 1, no conditioned word enters the FIFO. Instead, on every 8th edge counted from the edge where raw mode is first seen, one raw word is pushed. Each cycle contributes one byte: the XOR of the 16 bytes `src_i[8g+7:8g]`, with bits 127:125 taken as 0. The word is the last 8 such bytes, with the oldest in bits 63:56.
- R7: The FIFO holds 64 words in arrival order. A word produced while the FIFO is full at that edge is dropped, and the production timing is unchanged.
- R8: `rd_valid_o` is high exactly when the FIFO is non-empty, and a word is removed on an edge with `rd_valid_o` and `rd_ready_i` both high. While it is not taken, `rd_data_o` holds the head word; when the FIFO is empty, `rd_data_o` reads 0.
- R9: An edge with `rd_ready_i` high and the FIFO empty sets `underflow_o`. The flag stays set until reset.
- R10: Reset clears the FIFO and `underflow_o`, sets the LFSR to its seed, and restarts the R1 startup wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Entropy source bits; bits 127:125 are unused |
| ent_en_i | input | 1 | 1: sources feed the LFSR; 0: LFSR held at seed |
| raw_mode_i | input | 1 | 1: push raw folded samples instead of hash output |
| rd_ready_i | input | 1 | Reader accepts the head word |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| rd_data_o | output | 64 | Head word, 0 when empty |
| underflow_o | output | 1 | Sticky: a read was attempted while empty |

## Verification
A producer push and a reader pop can land on the same edge. The hardest case is when the FIFO is full at that edge, where R7 says the incoming word is lost even though a slot frees up. The bench provokes this by filling the FIFO in raw mode while the reader is stalled, then draining it. It also applies random ready patterns while words arrive every 8 cycles.

Outcomes are judged against a cycle-level reference queue, which applies the full-at-edge drop rule before the pop. Every head word and valid level is compared on each cycle, so one word kept or lost in error shifts the whole sequence and shows up.

// File: rtl/ent_cond_pkg.sv
package ent_cond_pkg;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] d;
    logic [31:0] e;
  } sha_st_t;

  localparam sha_st_t SHA_IV = '{a: 32'h67452301, b: 32'hEFCDAB89, c: 32'h98BADCFE,
                                 d: 32'h10325476, e: 32'hC3D2E1F0};

  function automatic logic [31:0] rotl(logic [31:0] x, int unsigned n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic sha_st_t sha_round(sha_st_t s, logic [31:0] w, logic [6:0] t);
    logic [31:0] f;
    logic [31:0] k;
    logic [31:0] tmp;
    sha_st_t r;
    if (t < 7'd20) begin
      f = (s.b & s.c) | (~s.b & s.d);
      k = 32'h5A827999;
    end else if (t < 7'd40) begin
      f = s.b ^ s.c ^ s.d;
      k = 32'h6ED9EBA1;
    end else if (t < 7'd60) begin
      f = (s.b & s.c) | (s.b & s.d) | (s.c & s.d);
      k = 32'h8F1BBCDC;
    end else begin
      f = s.b ^ s.c ^ s.d;
      k = 32'hCA62C1D6;
    end
    tmp = rotl(s.a, 5) + f + s.e + k + w;
    r.a = tmp;
    r.b = s.a;
    r.c = rotl(s.b, 30);
    r.d = s.c;
    r.e = s.d;
    return r;
  endfunction

  // single-block padding of a 16-byte message
  function automatic logic [511:0] pad_msg128(logic [127:0] m);
    return {m, 32'h8000_0000, 288'b0, 64'd128};
  endfunction

endpackage

// File: rtl/rng_lfsr_acc.sv
module rng_lfsr_acc #(
  parameter int              LFSR_W   = 128,
  parameter logic [LFSR_W-1:0] SEED   = 128'h5A3C96E10F87D2B41E2D3C4B5A697887,
  parameter logic [LFSR_W-1:0] TAP_MASK = (LFSR_W'(1) << 127) | (LFSR_W'(1) << 125) |
                                          (LFSR_W'(1) << 100) | (LFSR_W'(1) << 98)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_en_i,
  input  logic [LFSR_W-1:0] src_i,
  output logic [LFSR_W-1:0] state_d_o
);

  logic [LFSR_W-1:0] q;
  logic              fb;

  assign fb        = ^(q & TAP_MASK);
  assign state_d_o = ent_en_i ? ({q[LFSR_W-2:0], fb} ^ src_i) : SEED;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= state_d_o;
  end

endmodule

// File: rtl/rng_sha1_core.sv
module rng_sha1_core
  import ent_cond_pkg::*;
#(
  parameter int OUT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [127:0]     msg_i,
  output logic             done_o,
  output logic [OUT_W-1:0] digest_hi_o
);

  localparam int ROUNDS = 80;

  sha_st_t           st_q;
  logic [15:0][31:0] w_q;
  logic [6:0]        rnd_q;
  logic              act_q;
  logic [511:0]      blk;
  logic [31:0]       w_new;
  logic [63:0]       hi64;

  assign blk   = pad_msg128(msg_i);
  assign w_new = rotl(w_q[13] ^ w_q[8] ^ w_q[2] ^ w_q[0], 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      w_q   <= '0;
      rnd_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      st_q <= SHA_IV;
      for (int i = 0; i < 16; i++) w_q[i] <= blk[511-32*i -: 32];
      rnd_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (rnd_q == 7'(ROUNDS)) begin
        act_q <= 1'b0;
      end else begin
        st_q  <= sha_round(st_q, w_q[0], rnd_q);
        w_q   <= {w_new, w_q[15:1]};
        rnd_q <= rnd_q + 7'd1;
      end
    end
  end

  // finalisation cycle: feed-forward add, result consumed at the next edge
  assign done_o      = act_q && (rnd_q == 7'(ROUNDS));
  assign hi64        = {SHA_IV.a + st_q.a, SHA_IV.b + st_q.b};
  assign digest_hi_o = hi64[63 -: OUT_W];

endmodule

// File: rtl/rng_raw_sampler.sv
module rng_raw_sampler #(
  parameter int SRC_W = 128,
  parameter int BATCH = 8,
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int BYTE_W = WORD_W / BATCH;
  localparam int GROUPS = SRC_W / BYTE_W;
  localparam int CNT_W  = $clog2(BATCH);

  logic [BYTE_W-1:0] fold;
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    fold = '0;
    for (int g = 0; g < GROUPS; g++) fold ^= src_i[g*BYTE_W +: BYTE_W];
  end

  assign push_o = en_i && (cnt_q == CNT_W'(BATCH-1));
  assign word_o = {sr_q[WORD_W-BYTE_W-1:0], fold};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sr_q  <= word_o;
      cnt_q <= (cnt_q == CNT_W'(BATCH-1)) ? '0 : cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              underflow_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              empty, full, do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign do_wr = wr_i && !full;
  assign do_rd = rd_ready_i && !empty;

  assign rd_valid_o = !empty;
  assign rd_data_o  = empty ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q      <= '0;
      rptr_q      <= '0;
      cnt_q       <= '0;
      underflow_o <= 1'b0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + PTR_W'(1);
      if (do_rd) rptr_q <= (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
      if (rd_ready_i && empty) underflow_o <= 1'b1;
    end
  end

endmodule

// File: rtl/ent_cond_rng.sv
module ent_cond_rng #(
  parameter int SRC_W  = 128,
  parameter int USED_W = 125,
  parameter int WIN    = 81,
  parameter int BATCH  = 8,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              ent_en_i,
  input  logic              raw_mode_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              underflow_o
);

  localparam int WIN_W = $clog2(WIN);
  localparam logic [SRC_W-1:0] USE_MASK = {{(SRC_W-USED_W){1'b0}}, {USED_W{1'b1}}};

  logic [SRC_W-1:0]  src_used;
  logic [SRC_W-1:0]  lfsr_d;
  logic [WIN_W-1:0]  win_q;
  logic              snap;
  logic              h_done;
  logic [WORD_W-1:0] h_word;
  logic              r_push;
  logic [WORD_W-1:0] r_word;
  logic              wr;
  logic [WORD_W-1:0] wr_data;

  assign src_used = src_i & USE_MASK;
  assign snap     = (win_q == WIN_W'(WIN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_q <= '0;
    else if (snap) win_q <= '0;
    else           win_q <= win_q + WIN_W'(1);
  end

  rng_lfsr_acc #(.LFSR_W(SRC_W)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ent_en_i  (ent_en_i),
    .src_i     (src_used),
    .state_d_o (lfsr_d)
  );

  rng_sha1_core #(.OUT_W(WORD_W)) u_sha (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (snap),
    .msg_i       (lfsr_d),
    .done_o      (h_done),
    .digest_hi_o (h_word)
  );

  rng_raw_sampler #(.SRC_W(SRC_W), .BATCH(BATCH), .WORD_W(WORD_W)) u_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (raw_mode_i),
    .src_i  (src_used),
    .push_o (r_push),
    .word_o (r_word)
  );

  // raw sampler only pushes in raw mode, so the two sources never collide
  assign wr      = raw_mode_i ? r_push : h_done;
  assign wr_data = raw_mode_i ? r_word : h_word;

  rng_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .wr_data_i   (wr_data),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .underflow_o (underflow_o)
  );

endmodule

// File: rtl/ent_cond_rng_chk.sv
module ent_cond_rng_chk #(
  parameter int WORD_W    = 64,
  parameter int START_CYC = 162
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_ready_i,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              underflow_o
);

  localparam int CW = $clog2(START_CYC + 1);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cyc_q <= '0;
    else if (cyc_q != CW'(START_CYC))    cyc_q <= cyc_q + CW'(1);
  end

  // R1
  startup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < CW'(START_CYC)) |-> !rd_valid_o);

  // R8
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));

  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  // R9
  underflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_i && !rd_valid_o) |=> underflow_o);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

endmodule

bind ent_cond_rng ent_cond_rng_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_ready_i  (rd_ready_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .underflow_o (underflow_o)
);

// File: tb/ent_cond_rng_tb_top.sv
module ent_cond_rng_tb_top;

  localparam logic [127:0] SEED = 128'h5A3C96E10F87D2B41E2D3C4B5A697887;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] src;
  logic         en, raw, rdy;
  logic         valid, uf;
  logic [63:0]  data;

  always #5 clk = ~clk;

  ent_cond_rng dut_i (
    .clk_i (clk), .rst_ni (rst_n), .src_i (src), .ent_en_i (en),
    .raw_mode_i (raw), .rd_ready_i (rdy), .rd_valid_o (valid),
    .rd_data_o (data), .underflow_o (uf)
  );

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // reference SHA-1 of a 16-byte message, upper 64 bits of digest
  function automatic logic [63:0] sha_hi(logic [127:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 4; i++) w[i] = m[127-32*i -: 32];
    w[4] = 32'h80000000;
    for (int i = 5; i < 15; i++) w[i] = 32'h0;
    w[15] = 32'd128;
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {32'h67452301 + a, 32'hEFCDAB89 + b};
  endfunction

  function automatic logic [7:0] fold8(logic [127:0] s);
    logic [127:0] u;
    logic [7:0] f;
    u = {3'b000, s[124:0]};
    f = 8'h00;
    for (int g = 0; g < 16; g++) f ^= u[8*g +: 8];
    return f;
  endfunction

  // cycle-level reference model
  logic [127:0] m_lfsr;
  int           m_win, m_hcnt, m_rcnt;
  bit           m_act, m_uf;
  logic [63:0]  m_pend, m_rsr;
  logic [63:0]  q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lfsr = SEED; m_win = 0; m_hcnt = 0; m_rcnt = 0;
      m_act = 0; m_uf = 0; m_pend = '0; m_rsr = '0;
      q.delete();
    end else begin
      logic [127:0] nx;
      logic [63:0]  pw;
      logic [7:0]   fb8;
      bit           push, full0;
      push = 0; pw = '0;
      nx = en ? ({m_lfsr[126:0], m_lfsr[127]^m_lfsr[125]^m_lfsr[100]^m_lfsr[98]} ^ {3'b000, src[124:0]})
              : SEED;
      if (m_win == 80) begin
        if (m_act && m_hcnt == 80 && !raw) begin push = 1; pw = m_pend; end
        m_pend = sha_hi(nx); m_act = 1; m_hcnt = 0; m_win = 0;
      end else begin
        m_win++;
        if (m_act) begin
          if (m_hcnt == 80) begin
            m_act = 0;
            if (!raw) begin push = 1; pw = m_pend; end
          end else m_hcnt++;
        end
      end
      if (raw) begin
        fb8 = fold8(src);
        if (m_rcnt == 7) begin push = 1; pw = {m_rsr[55:0], fb8}; m_rcnt = 0; end
        else m_rcnt++;
        m_rsr = {m_rsr[55:0], fb8};
      end else m_rcnt = 0;
      full0 = (q.size() == 64);
      if (rdy) begin
        if (q.size() > 0) void'(q.pop_front());
        else m_uf = 1;
      end
      if (push && !full0) q.push_back(pw);
      m_lfsr = nx;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  int cyc_no   = 0;
  int last_acc = -1;

  // check outputs against the model at the negedge, then drive the next inputs
  task automatic tick(string req, bit r, bit e, bit rw, int gap);
    @(negedge clk);
    chk(valid == (q.size() != 0), req, 64'(valid), 64'(q.size() != 0));
    if (q.size() != 0) chk(data == q[0], req, data, q[0]);
    else chk(data == 64'h0, "R8", data, 64'h0);
    chk(uf == m_uf, "R9", 64'(uf), 64'(m_uf));
    if (valid && rdy) begin
      if (gap != 0 && last_acc >= 0) chk((cyc_no - last_acc) == gap, "R3/R6 spacing",
                                         64'(cyc_no - last_acc), 64'(gap));
      last_acc = cyc_no;
    end
    cyc_no++;
    rdy = r; en = e; raw = rw;
    src = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rdy = 0; en = 0; raw = 0; src = '0;
    @(negedge clk);
    // R10
    chk(valid == 1'b0, "R10", 64'(valid), 64'h0);
    chk(uf == 1'b0, "R10", 64'(uf), 64'h0);
    chk(data == 64'h0, "R10", data, 64'h0);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] d0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; rdy = 0; en = 0; raw = 0; src = '0;
    do_reset();

    // R1 / R5: startup window with entropy disabled
    repeat (161) @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b0, "R1 edge 161", 64'(valid), 64'h0);
    @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b1, "R1 edge 162", 64'(valid), 64'h1);
    chk(data == sha_hi(SEED), "R5 self-test word", data, sha_hi(SEED));

    // R5 / R3: repeated self-test words, 81-cycle spacing
    last_acc = -1;
    repeat (300) tick("R5", 1, 0, 0, 81);

    // R2 / R4 / R3: random entropy, top source bits randomised but ignored by model
    last_acc = -1;
    repeat (1000) tick("R2 R4", 1, 1, 0, 81);

    // R6: raw mode, continuous reads
    tick("R6", 1, 1, 1, 0);
    last_acc = -1;
    repeat (30) tick("R6", 1, 1, 1, 0);
    repeat (200) tick("R6", 1, 1, 1, 8);
    repeat (200) tick("R6", 1'($urandom_range(0, 1)), 1, 1, 0);

    // R7: overfill the FIFO while stalled, then drain
    repeat (700) tick("R7", 0, 1, 1, 0);
    chk(q.size() == 64, "R7 model full", 64'(q.size()), 64'd64);
    @(negedge clk);
    d0 = data;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(data == d0, "R8 hold", data, d0);
    chk(valid == 1'b1, "R8 hold", 64'(valid), 64'h1);
    repeat (120) tick("R7", 1, 1, 0, 0);

    // R9: read from empty FIFO
    repeat (20) tick("R9", 0, 1, 0, 0);
    while (q.size() != 0) tick("R9", 1, 1, 0, 0);
    tick("R9", 1, 1, 0, 0);
    tick("R9", 0, 1, 0, 0);
    chk(uf == 1'b1, "R9 set", 64'(uf), 64'h1);
    repeat (200) tick("R9", 1'($urandom_range(0, 1)), 1, 0, 0);
    chk(uf == 1'b1, "R9 sticky", 64'(uf), 64'h1);

    // R10 / R1: reset mid-run with entropy on
    do_reset();
    en = 1;
    repeat (161) tick("R1", 0, 1, 0, 0);
    chk(valid == 1'b0, "R1 after reset", 64'(valid), 64'h0);
    repeat (2) tick("R1", 0, 1, 0, 0);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) begin
        en  = 1'($urandom_range(0, 1));
        raw = 1'($urandom_range(0, 3) == 0);
      end
      tick("R2 R6 R7", 1'($urandom_range(0, 3) != 0), en, raw, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule